// File: doc/BRIEF.md
# Interrupt and Bus-Request Arbiter

This block sits beside a processor's sequencer and decides, at each boundary, what the core does next. It can hand the bus to an external master, enter the non-maskable service routine, accept a maskable interrupt, or let the core carry on. A bus request is sampled at every machine-cycle boundary. Interrupts are sampled only at an instruction boundary, which the sequencer marks by raising `instr_end` together with `cyc_end`. The order of precedence is bus request first, then the non-maskable interrupt, then the maskable one.

The block holds the interrupt-enable flip-flop, the two-bit interrupt mode and the eight-bit vector-page register. Software loads them through plain strobe pins.

A non-maskable request is caught on its falling edge and jumps to a fixed target. A maskable request is handled according to the mode:
- **Fixed mode** jumps straight to a fixed target.
- **Vector mode** runs an acknowledge phase and then forms the target from the page register and the byte that the device supplies.
- **Injection mode** runs the same acknowledge phase and then passes the device byte on as an opcode for the core to execute.

Data moves through three valid/ready channels:
- the device byte, where `byte_ready` is raised only during the acknowledge phase;
- the jump target, `tgt_*`;
- the injected opcode, `op_*`.

A producer holds its valid signal and its payload until the ready side accepts them. `tgt_valid` and `op_valid` stay asserted, with a stable payload, for as long as ready is low. A channel transfers on a clock edge where valid and ready are both high.

Top module: `irq_bus_arbiter`

## Requirements
- R1: Reset takes effect only when `rst_n` has been sampled low on three consecutive rising edges. At that edge the outputs go idle (`busack_n`=1, `bus_float`=0, no valid, acknowledge pins high), the enable is cleared, the mode becomes 0 (injection) and the page register becomes 00h. A low pulse of two clocks changes nothing.
- R2: `busreq_n` low is granted only on an edge where `cyc_end`=1. From the next clock `busack_n`=0 and `bus_float`=1. The grant is kept while `busreq_n` stays low and is dropped on the clock after `busreq_n` is sampled high, whatever `cyc_end` is doing.
- R3: When a bus request and an interrupt are both present at an instruction end, the grant wins. The interrupt is still taken at the first instruction end after the bus is released.
- R4: A falling edge on `nmi_n` is latched at any time, including during a grant. It is serviced at the next instruction end whether or not the enable is set, and gives target 0066h. Holding `nmi_n` low with no new edge does not trigger a second service.
- R5: A low `int_n` is accepted only at an instruction end while the enable is set. A pending NMI is served before it.
- R6: Accepting either kind of interrupt clears the enable.
- R7: Mode 1 gives target 0038h with no acknowledge phase.
- R8: Mode 2 enters an acknowledge phase in which `ack_m1_n` and `ack_iorq_n` are both low and `byte_ready`=1. The phase lasts until `byte_valid` is seen. The target is then {page register, byte}.
- R9: Mode 0 runs the same acknowledge phase and then presents the device byte on `op_byte` with `op_valid`.
- R10: `tgt_valid` or `op_valid` holds with a stable payload while its ready is low. On the clock after the transfer the block returns to normal running.
- R11: A mode write of value 3 is ignored. When `di_clr` and `ei_set` arrive in the same cycle, `di_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset request, active low, must be held for three clocks |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| int_n | input | 1 | Maskable interrupt, active low level |
| cyc_end | input | 1 | Last clock of a machine cycle |
| instr_end | input | 1 | Last cycle of an instruction, only counted together with cyc_end |
| ei_set | input | 1 | Set the interrupt enable |
| di_clr | input | 1 | Clear the interrupt enable |
| mode_we | input | 1 | Load the interrupt mode |
| mode_wdata | input | 2 | New mode: 0 injection, 1 fixed, 2 vector |
| ireg_we | input | 1 | Load the vector page register |
| ireg_wdata | input | 8 | New page value |
| byte_valid | input | 1 | Device byte valid |
| byte_ready | output | 1 | Acknowledge phase open, device byte accepted |
| byte_data | input | 8 | Device byte |
| tgt_valid | output | 1 | Jump target valid |
| tgt_ready | input | 1 | Core accepts jump target |
| tgt_addr | output | 16 | Jump target address |
| op_valid | output | 1 | Injected opcode valid |
| op_ready | input | 1 | Core accepts injected opcode |
| op_byte | output | 8 | Injected opcode |
| busack_n | output | 1 | Bus granted, active low |
| bus_float | output | 1 | Float address, data and strobe drivers |
| ack_m1_n | output | 1 | Acknowledge cycle marker, low with ack_iorq_n |
| ack_iorq_n | output | 1 | Acknowledge cycle marker, low with ack_m1_n |

## Verification
The assertions assume the following about the inputs:
- `instr_end` matters only when it arrives together with `cyc_end`.
- `byte_data` is steady during any cycle in which `byte_valid` is high.
- `rst_n` changes only between clock edges.

The stimulus changes every input on the falling clock edge and raises `instr_end` only alongside `cyc_end`. It drives the device byte only in the cycle where it presents `byte_valid`, and it holds every reset for whole clock periods.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_GRANT = 3'd1,
    ST_ACK   = 3'd2,
    ST_TGT   = 3'd3,
    ST_OPC   = 3'd4
  } arb_state_e;

  localparam logic [1:0] MODE_INJECT = 2'd0;
  localparam logic [1:0] MODE_FIXED  = 2'd1;
  localparam logic [1:0] MODE_VEC    = 2'd2;
  localparam logic [1:0] MODE_BAD    = 2'd3;
endpackage

// File: rtl/arb_rst_filter.sv
`timescale 1ns/1ps
// Core reset fires only after HOLD consecutive low samples of rst_n.
module arb_rst_filter #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst
);
  localparam int unsigned HW = HOLD - 1;
  logic [HW-1:0] hist;

  generate
    if (HW > 1) begin : g_shift
      always_ff @(posedge clk) hist <= {hist[HW-2:0], rst_n};
    end else begin : g_single
      always_ff @(posedge clk) hist <= rst_n;
    end
  endgenerate

  assign core_rst = ~rst_n & (hist == '0);
endmodule

// File: rtl/arb_nmi_latch.sv
`timescale 1ns/1ps
// Falling-edge capture of the non-maskable request; set wins over service.
module arb_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic serviced,
  output logic pend
);
  logic nmi_q;
  logic fall;

  assign fall = nmi_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b1;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_n;
      pend  <= (pend & ~serviced) | fall;
    end
  end

  assert_nmi_edge_latched_R4: assert property (@(posedge clk) disable iff (rst)
    (nmi_q && !nmi_n) |=> pend);
  assert_nmi_cleared_when_served_R4: assert property (@(posedge clk) disable iff (rst)
    (serviced && nmi_n) |=> !pend);
endmodule

// File: rtl/arb_ctl_regs.sv
`timescale 1ns/1ps
// Enable flip-flop, interrupt mode and vector page register.
module arb_ctl_regs
  import arb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ei_set,
  input  logic          di_clr,
  input  logic          take_any,
  input  logic          mode_we,
  input  logic [1:0]    mode_wdata,
  input  logic          ireg_we,
  input  logic [DW-1:0] ireg_wdata,
  output logic          ie,
  output logic [1:0]    mode,
  output logic [DW-1:0] ireg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie   <= 1'b0;
      mode <= MODE_INJECT;
      ireg <= '0;
    end else begin
      if (take_any || di_clr) ie <= 1'b0;
      else if (ei_set)        ie <= 1'b1;
      if (mode_we && mode_wdata != MODE_BAD) mode <= mode_wdata;
      if (ireg_we) ireg <= ireg_wdata;
    end
  end

  assert_ie_cleared_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
    take_any |=> !ie);
  assert_bad_mode_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_wdata == MODE_BAD) |=> $stable(mode));
  assert_di_beats_ei_R11: assert property (@(posedge clk) disable iff (rst)
    (di_clr && ei_set) |=> !ie);
endmodule

// File: rtl/irq_bus_arbiter.sv
`timescale 1ns/1ps
module irq_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned       DW         = 8,
  parameter int unsigned       RST_HOLD   = 3,
  parameter logic [2*DW-1:0]   NMI_TARGET = 'h0066,
  parameter logic [2*DW-1:0]   IM1_TARGET = 'h0038
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busreq_n,
  input  logic            nmi_n,
  input  logic            int_n,
  input  logic            cyc_end,
  input  logic            instr_end,
  input  logic            ei_set,
  input  logic            di_clr,
  input  logic            mode_we,
  input  logic [1:0]      mode_wdata,
  input  logic            ireg_we,
  input  logic [DW-1:0]   ireg_wdata,
  input  logic            byte_valid,
  output logic            byte_ready,
  input  logic [DW-1:0]   byte_data,
  output logic            tgt_valid,
  input  logic            tgt_ready,
  output logic [2*DW-1:0] tgt_addr,
  output logic            op_valid,
  input  logic            op_ready,
  output logic [DW-1:0]   op_byte,
  output logic            busack_n,
  output logic            bus_float,
  output logic            ack_m1_n,
  output logic            ack_iorq_n
);
  localparam int unsigned AW = 2 * DW;

  logic          core_rst;
  logic          nmi_pend;
  logic          ie;
  logic [1:0]    mode;
  logic [DW-1:0] ireg;
  logic          take_nmi, take_int;
  logic          at_ins;

  arb_state_e    state, state_n;
  logic [AW-1:0] tgt_q, tgt_n;
  logic          ld_tgt, ld_op;
  logic [DW-1:0] op_q;
  logic [1:0]    acc_mode;

  arb_rst_filter #(.HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst));

  arb_nmi_latch u_nmi (
    .clk(clk), .rst(core_rst), .nmi_n(nmi_n), .serviced(take_nmi), .pend(nmi_pend));

  arb_ctl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(core_rst), .ei_set(ei_set), .di_clr(di_clr),
    .take_any(take_nmi | take_int), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ireg_we(ireg_we), .ireg_wdata(ireg_wdata), .ie(ie), .mode(mode), .ireg(ireg));

  assign at_ins = cyc_end & instr_end;

  always_comb begin
    state_n  = state;
    take_nmi = 1'b0;
    take_int = 1'b0;
    ld_tgt   = 1'b0;
    ld_op    = 1'b0;
    tgt_n    = tgt_q;
    case (state)
      ST_RUN: begin
        if (cyc_end && !busreq_n) begin
          state_n = ST_GRANT;                 // bus request outranks everything
        end else if (at_ins && nmi_pend) begin
          take_nmi = 1'b1;
          ld_tgt   = 1'b1;
          tgt_n    = NMI_TARGET;
          state_n  = ST_TGT;
        end else if (at_ins && !int_n && ie) begin
          take_int = 1'b1;
          if (mode == MODE_FIXED) begin
            ld_tgt  = 1'b1;
            tgt_n   = IM1_TARGET;
            state_n = ST_TGT;
          end else begin
            state_n = ST_ACK;
          end
        end
      end
      ST_GRANT: if (busreq_n) state_n = ST_RUN;
      ST_ACK: begin
        if (byte_valid) begin
          if (acc_mode == MODE_VEC) begin
            ld_tgt  = 1'b1;
            tgt_n   = {ireg, byte_data};
            state_n = ST_TGT;
          end else begin
            ld_op   = 1'b1;
            state_n = ST_OPC;
          end
        end
      end
      ST_TGT:  if (tgt_ready) state_n = ST_RUN;
      ST_OPC:  if (op_ready)  state_n = ST_RUN;
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      state    <= ST_RUN;
      tgt_q    <= '0;
      op_q     <= '0;
      acc_mode <= MODE_INJECT;
    end else begin
      state <= state_n;
      if (ld_tgt)   tgt_q    <= tgt_n;
      if (ld_op)    op_q     <= byte_data;
      if (take_int) acc_mode <= mode;
    end
  end

  assign busack_n   = (state != ST_GRANT);
  assign bus_float  = (state == ST_GRANT);
  assign byte_ready = (state == ST_ACK);
  assign ack_m1_n   = (state != ST_ACK);
  assign ack_iorq_n = (state != ST_ACK);
  assign tgt_valid  = (state == ST_TGT);
  assign tgt_addr   = tgt_q;
  assign op_valid   = (state == ST_OPC);
  assign op_byte    = op_q;

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $past(core_rst) |-> (busack_n && !bus_float && !tgt_valid && !op_valid && !byte_ready));
  assert_grant_at_cycle_end_R2: assert property (@(posedge clk) disable iff (core_rst)
    $fell(busack_n) |-> $past(cyc_end && !busreq_n));
  assert_grant_release_R2: assert property (@(posedge clk) disable iff (core_rst)
    (!busack_n && busreq_n) |=> busack_n);
  assert_bus_beats_irq_R3: assert property (@(posedge clk) disable iff (core_rst)
    (at_ins && !busreq_n && busack_n && !byte_ready && !tgt_valid && !op_valid)
    |=> (!busack_n && !tgt_valid && !byte_ready));
  assert_nmi_target_R4: assert property (@(posedge clk) disable iff (core_rst)
    take_nmi |=> (tgt_valid && tgt_addr == NMI_TARGET));
  assert_int_needs_enable_R5: assert property (@(posedge clk) disable iff (core_rst)
    $rose(byte_ready) |-> $past(ie && at_ins && !int_n));
  assert_fixed_mode_no_ack_R7: assert property (@(posedge clk) disable iff (core_rst)
    (take_int && mode == MODE_FIXED) |=> (tgt_valid && !byte_ready && tgt_addr == IM1_TARGET));
  assert_vector_formed_R8: assert property (@(posedge clk) disable iff (core_rst)
    (byte_ready && byte_valid && acc_mode == MODE_VEC)
    |=> (tgt_valid && tgt_addr == {$past(ireg), $past(byte_data)}));
  assert_opcode_injected_R9: assert property (@(posedge clk) disable iff (core_rst)
    (byte_ready && byte_valid && acc_mode == MODE_INJECT)
    |=> (op_valid && op_byte == $past(byte_data)));
  assert_tgt_hold_R10: assert property (@(posedge clk) disable iff (core_rst)
    (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_addr)));
  assert_op_hold_R10: assert property (@(posedge clk) disable iff (core_rst)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_byte)));
endmodule

// File: tb/sim_irq_bus_arbiter.sv
`timescale 1ns/1ps
module sim_irq_bus_arbiter;
  // pins: {rst_n, busreq_n, nmi_n, int_n, cyc_end, instr_end}
  localparam logic [5:0] P_IDLE  = 6'b111100;
  localparam logic [5:0] P_INT   = 6'b111000;
  localparam logic [5:0] P_INTI  = 6'b111011;
  localparam logic [5:0] P_BRQ   = 6'b101100;
  localparam logic [5:0] P_BRQC  = 6'b101110;
  localparam logic [5:0] P_BRQN  = 6'b100100;
  localparam logic [5:0] P_NMI   = 6'b110100;
  localparam logic [5:0] P_NMII  = 6'b110111;
  localparam logic [5:0] P_NI    = 6'b110000;
  localparam logic [5:0] P_NII   = 6'b110011;
  localparam logic [5:0] P_BRQII = 6'b101011;
  localparam logic [5:0] P_RST   = 6'b011100;

  localparam logic [2:0] C_NONE = 3'd0, C_EI = 3'd1, C_DI = 3'd2, C_MODE = 3'd3,
                         C_IREG = 3'd4, C_BYTE = 3'd5, C_STALL = 3'd6, C_EIDI = 3'd7;

  typedef struct packed {
    logic [3:0]  r;
    logic [5:0]  pins;
    logic [2:0]  cmd;
    logic [7:0]  dat;
    logic        e_bus;
    logic        e_ack;
    logic        e_tv;
    logic [15:0] e_addr;
    logic        e_ov;
    logic [7:0]  e_op;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    '{4'd7,  P_IDLE,  C_MODE,  8'h01, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R7 setup
    '{4'd5,  P_IDLE,  C_EI,    8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd5,  P_INT,   C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R5 not at instr end
    '{4'd7,  P_INTI,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b1, 16'h0038, 1'b0, 8'h00}, // R7 fixed target
    '{4'd10, P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R10 back to run
    '{4'd6,  P_INTI,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R6 enable cleared
    '{4'd11, P_IDLE,  C_MODE,  8'h03, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R11 mode 3 write
    '{4'd11, P_IDLE,  C_EI,    8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd11, P_INTI,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b1, 16'h0038, 1'b0, 8'h00}, // R11 still mode 1
    '{4'd10, P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd8,  P_IDLE,  C_IREG,  8'hA5, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd8,  P_IDLE,  C_MODE,  8'h02, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd8,  P_IDLE,  C_EI,    8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd8,  P_INTI,  C_NONE,  8'h00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00}, // R8 ack phase
    '{4'd8,  P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00}, // R8 waits for byte
    '{4'd8,  P_IDLE,  C_BYTE,  8'h3C, 1'b0, 1'b0, 1'b1, 16'hA53C, 1'b0, 8'h00}, // R8 vector
    '{4'd10, P_IDLE,  C_STALL, 8'h00, 1'b0, 1'b0, 1'b1, 16'hA53C, 1'b0, 8'h00}, // R10 hold
    '{4'd10, P_IDLE,  C_STALL, 8'h00, 1'b0, 1'b0, 1'b1, 16'hA53C, 1'b0, 8'h00},
    '{4'd10, P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd9,  P_IDLE,  C_MODE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd9,  P_IDLE,  C_EI,    8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd9,  P_INTI,  C_NONE,  8'h00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00}, // R9 ack phase
    '{4'd9,  P_IDLE,  C_BYTE,  8'hFF, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 8'hFF}, // R9 opcode out
    '{4'd10, P_IDLE,  C_STALL, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 8'hFF}, // R10 op hold
    '{4'd10, P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd2,  P_BRQ,   C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R2 no cycle end
    '{4'd2,  P_BRQC,  C_NONE,  8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R2 granted
    '{4'd4,  P_BRQN,  C_NONE,  8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R4 edge while granted
    '{4'd2,  P_NMI,   C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R2 released
    '{4'd4,  P_NMII,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b1, 16'h0066, 1'b0, 8'h00}, // R4 NMI, enable off
    '{4'd4,  P_NMI,   C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd4,  P_NMII,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R4 no retrigger
    '{4'd5,  P_IDLE,  C_EI,    8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd5,  P_NI,    C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd5,  P_NII,   C_NONE,  8'h00, 1'b0, 1'b0, 1'b1, 16'h0066, 1'b0, 8'h00}, // R5 NMI over INT
    '{4'd5,  P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd6,  P_INTI,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R6 NMI cleared enable
    '{4'd3,  P_IDLE,  C_EI,    8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd3,  P_BRQII, C_NONE,  8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R3 bus wins
    '{4'd3,  P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd3,  P_INTI,  C_NONE,  8'h00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00}, // R3 INT taken later
    '{4'd3,  P_IDLE,  C_BYTE,  8'hC7, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 8'hC7},
    '{4'd3,  P_IDLE,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{4'd11, P_IDLE,  C_EIDI,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}, // R11 both strobes
    '{4'd11, P_INTI,  C_NONE,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00}  // R11 disable won
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, busreq_n, nmi_n, int_n, cyc_end, instr_end;
  logic ei_set, di_clr, mode_we, ireg_we, byte_valid, tgt_ready, op_ready;
  logic [1:0] mode_wdata;
  logic [7:0] ireg_wdata, byte_data;
  logic byte_ready, tgt_valid, op_valid, busack_n, bus_float, ack_m1_n, ack_iorq_n;
  logic [15:0] tgt_addr;
  logic [7:0]  op_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  irq_bus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
    .cyc_end(cyc_end), .instr_end(instr_end), .ei_set(ei_set), .di_clr(di_clr),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .ireg_we(ireg_we), .ireg_wdata(ireg_wdata),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr),
    .op_valid(op_valid), .op_ready(op_ready), .op_byte(op_byte),
    .busack_n(busack_n), .bus_float(bus_float), .ack_m1_n(ack_m1_n), .ack_iorq_n(ack_iorq_n));

  task automatic apply(input vec_t v, input int idx);
    bit ok;
    @(negedge clk);
    {rst_n, busreq_n, nmi_n, int_n, cyc_end, instr_end} = v.pins;
    ei_set     = (v.cmd == C_EI)  || (v.cmd == C_EIDI);
    di_clr     = (v.cmd == C_DI)  || (v.cmd == C_EIDI);
    mode_we    = (v.cmd == C_MODE);
    ireg_we    = (v.cmd == C_IREG);
    byte_valid = (v.cmd == C_BYTE);
    tgt_ready  = (v.cmd != C_STALL);
    op_ready   = (v.cmd != C_STALL);
    mode_wdata = v.dat[1:0];
    ireg_wdata = v.dat;
    byte_data  = v.dat;
    @(posedge clk);
    #1;
    ok = (busack_n == !v.e_bus) && (bus_float == v.e_bus) &&
         (ack_m1_n == !v.e_ack) && (ack_iorq_n == !v.e_ack) && (byte_ready == v.e_ack) &&
         (tgt_valid == v.e_tv) && (!v.e_tv || tgt_addr == v.e_addr) &&
         (op_valid == v.e_ov) && (!v.e_ov || op_byte == v.e_op);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d step %0d: got busack_n=%b float=%b m1_n=%b iorq_n=%b brdy=%b tv=%b addr=%h ov=%b op=%h; exp bus=%b ack=%b tv=%b addr=%h ov=%b op=%h",
               v.r, idx, busack_n, bus_float, ack_m1_n, ack_iorq_n, byte_ready, tgt_valid,
               tgt_addr, op_valid, op_byte, v.e_bus, v.e_ack, v.e_tv, v.e_addr, v.e_ov, v.e_op);
    end
  endtask

  function automatic vec_t mk(input logic [3:0] r, input logic [5:0] p, input logic [2:0] c,
                              input logic [7:0] d, input logic ack, input logic tv,
                              input logic [15:0] a, input logic ov, input logic [7:0] o);
    vec_t v;
    v = '{r, p, c, d, 1'b0, ack, tv, a, ov, o};
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; busreq_n = 1'b1; nmi_n = 1'b1; int_n = 1'b1; cyc_end = 1'b0;
    instr_end = 1'b0; ei_set = 1'b0; di_clr = 1'b0; mode_we = 1'b0; ireg_we = 1'b0;
    byte_valid = 1'b0; tgt_ready = 1'b1; op_ready = 1'b1; mode_wdata = '0;
    ireg_wdata = '0; byte_data = '0;
    // R1: initial reset held four clocks, outputs idle afterwards
    for (int i = 0; i < 4; i++) apply(mk(4'd1, P_RST, C_NONE, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), i);
    for (int i = 0; i < NV; i++) apply(VECS[i], i);

    // R1: a two-clock low pulse must not reset mode 1 or the enable
    apply(mk(4'd1, P_IDLE, C_MODE, 8'h01, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 100);
    apply(mk(4'd1, P_IDLE, C_EI,   8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 101);
    apply(mk(4'd1, P_RST,  C_NONE, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 102);
    apply(mk(4'd1, P_RST,  C_NONE, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 103);
    apply(mk(4'd1, P_INTI, C_NONE, 8'h00, 1'b0, 1'b1, 16'h0038, 1'b0, 8'h0), 104);
    apply(mk(4'd1, P_IDLE, C_NONE, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 105);
    // R1: full reset clears enable, mode and page register
    apply(mk(4'd1, P_IDLE, C_IREG, 8'h5A, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 106);
    apply(mk(4'd1, P_IDLE, C_EI,   8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 107);
    for (int i = 0; i < 3; i++) apply(mk(4'd1, P_RST, C_NONE, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 108 + i);
    apply(mk(4'd1, P_INTI, C_NONE, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 111);
    apply(mk(4'd1, P_IDLE, C_EI,   8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 112);
    apply(mk(4'd1, P_INTI, C_NONE, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0), 113);
    apply(mk(4'd1, P_IDLE, C_BYTE, 8'h09, 1'b0, 1'b0, 16'h0, 1'b1, 8'h09), 114);
    apply(mk(4'd1, P_IDLE, C_MODE, 8'h02, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 115);
    apply(mk(4'd1, P_IDLE, C_EI,   8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 116);
    apply(mk(4'd1, P_INTI, C_NONE, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0), 117);
    apply(mk(4'd1, P_IDLE, C_BYTE, 8'h12, 1'b0, 1'b1, 16'h0012, 1'b0, 8'h0), 118);
    apply(mk(4'd1, P_IDLE, C_NONE, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0), 119);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule